// File: doc/BRIEF.md
# Iterative AES-128 Block Decryption Core

This core turns one 128-bit AES-128 cipher block back into plain text. A host writes the cipher block as four 32-bit words into an input buffer, then pulses `start`. The core XORs the buffered block with the last round key in the first clock. It then completes one whole inverse round in each following clock, so the plain text lands in an output buffer ten clocks after the start edge. The `done` flag rises one clock after that.

The round keys are not generated here. The core drives a round-key index, and an external key table answers combinationally with the matching 128-bit key. The index steps down from 10 to 0 as the rounds advance. InvShiftRows is pure wiring. InvSubBytes computes the inverse S-box arithmetically. InvMixColumns is built from doubling steps with a conditional reduction by 0x1B, so it needs no general multiplier.

Top module: `blkdec_core`

## Requirements
- R1: After reset, `done` is 0, `rk_idx` is 10 and `rd_word` is 0 for every `rd_idx`.
- R2: A write with `wr_en` high stores `wr_word` as column `wr_idx` of the input block. Column 0 occupies bits 127:96, and its most significant byte is the block's first byte in AES byte order.
- R3: While idle, `rk_idx` is 10. After an accepted start edge it reads 9, 8, … down to 0, stepping once per clock. It returns to 10 after the clock that consumes key 0.
- R4: The plain text is the AES-128 decryption of the buffered cipher block under the key schedule supplied through `rk_data`. This includes the FIPS-197 AES-128 example vector.
- R5: `done` is low after the first 10 clock edges following an accepted start edge. It is high after the 11th.
- R6: `done` stays high until the next accepted start edge, and that edge clears it.
- R7: A `start` pulse that arrives while a computation is running is ignored. The key index sequence, the completion time and the result are unchanged.
- R8: The output buffer keeps its result while new input words are written. It changes only when a later computation completes.
- R9: `rd_word` returns column `rd_idx` of the output block, with column 0 on bits 127:96 of the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write `wr_word` into the input buffer |
| wr_idx | input | 2 | Column selected for the write |
| wr_word | input | 32 | Cipher-text word |
| start | input | 1 | Begin a decryption (ignored while busy) |
| rk_idx | output | 4 | Round-key index presented to the key table |
| rk_data | input | 128 | Round key for `rk_idx`, combinational |
| done | output | 1 | Result available |
| rd_idx | input | 2 | Column selected for readback |
| rd_word | output | 32 | Plain-text word |

## Verification
The start edge is the reference point, and every check is counted from it. The bench samples on the falling edge after the start edge and expects `rk_idx` = 9. On each following falling edge it expects the index one lower, and `done` low throughout. After the 10th edge it expects `done` still low with the index back at 10. After the 11th edge it expects `done` high. The readback words are combinational from the output buffer, so the bench compares them once `done` is seen. A second start injected mid-run must leave every one of these expectations unchanged.

// File: rtl/blkdec_pkg.sv
package blkdec_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIN  = 2'd2
    } phase_e;

    // multiply by x in GF(2^8) with reduction polynomial 0x11B
    function automatic logic [7:0] gf_dbl(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] p;
        acc = 8'h00;
        p   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ p;
            p = gf_dbl(p);
        end
        return acc;
    endfunction

    // a^254 is the multiplicative inverse (0 maps to 0)
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] res;
        logic [7:0] p;
        res = 8'h01;
        p   = a;
        for (int i = 1; i < 8; i++) begin
            p   = gf_mul(p, p);
            res = gf_mul(res, p);
        end
        return res;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    function automatic logic [7:0] inv_sbox(input logic [7:0] x);
        logic [7:0] t;
        t = rotl8(x, 1) ^ rotl8(x, 3) ^ rotl8(x, 6) ^ 8'h05;
        return gf_inv(t);
    endfunction

endpackage

// File: rtl/blkdec_invsub.sv
module blkdec_invsub
    import blkdec_pkg::*;
(
    input  logic [7:0] din,
    output logic [7:0] dout
);
    always_comb dout = inv_sbox(din);
endmodule

// File: rtl/blkdec_invmix.sv
module blkdec_invmix
    import blkdec_pkg::*;
(
    input  logic [31:0] col_in,
    output logic [31:0] col_out
);
    logic [7:0] a  [4];
    logic [7:0] m9 [4];
    logic [7:0] mb [4];
    logic [7:0] md [4];
    logic [7:0] me [4];

    for (genvar r = 0; r < 4; r++) begin : g_byte
        logic [7:0] x2, x4, x8;
        assign a[r]  = col_in[31-8*r -: 8];
        assign x2    = gf_dbl(a[r]);
        assign x4    = gf_dbl(x2);
        assign x8    = gf_dbl(x4);
        assign m9[r] = x8 ^ a[r];
        assign mb[r] = x8 ^ x2 ^ a[r];
        assign md[r] = x8 ^ x4 ^ a[r];
        assign me[r] = x8 ^ x4 ^ x2;
    end

    for (genvar r = 0; r < 4; r++) begin : g_out
        assign col_out[31-8*r -: 8] = me[r] ^ mb[(r+1)%4] ^ md[(r+2)%4] ^ m9[(r+3)%4];
    end
endmodule

// File: rtl/blkdec_round.sv
module blkdec_round (
    input  logic [127:0] st_in,
    input  logic [127:0] rkey,
    input  logic         last,
    output logic [127:0] st_out
);
    logic [127:0] shifted;
    logic [127:0] subbed;
    logic [127:0] keyed;
    logic [127:0] mixed;

    // inverse row rotation: row r moves right by r columns (wiring only)
    for (genvar b = 0; b < 16; b++) begin : g_byte
        localparam int ROW = b % 4;
        localparam int COL = b / 4;
        localparam int SRC = 4 * ((COL - ROW + 4) % 4) + ROW;
        assign shifted[127-8*b -: 8] = st_in[127-8*SRC -: 8];
        blkdec_invsub u_sub (
            .din  (shifted[127-8*b -: 8]),
            .dout (subbed[127-8*b -: 8])
        );
    end

    assign keyed = subbed ^ rkey;

    for (genvar c = 0; c < 4; c++) begin : g_col
        blkdec_invmix u_mix (
            .col_in  (keyed[127-32*c -: 32]),
            .col_out (mixed[127-32*c -: 32])
        );
    end

    assign st_out = last ? keyed : mixed;
endmodule

// File: rtl/blkdec_core.sv
module blkdec_core
    import blkdec_pkg::*;
#(
    parameter int NROUNDS = 10,
    parameter int WORD_W  = 32,
    localparam int BLK_W  = 128,
    localparam int NWORDS = BLK_W / WORD_W,
    localparam int SEL_W  = $clog2(NWORDS),
    localparam int IDX_W  = $clog2(NROUNDS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_idx,
    input  logic [WORD_W-1:0]  wr_word,
    input  logic               start,
    output logic [IDX_W-1:0]   rk_idx,
    input  logic [BLK_W-1:0]   rk_data,
    output logic               done,
    input  logic [SEL_W-1:0]   rd_idx,
    output logic [WORD_W-1:0]  rd_word
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NROUNDS);

    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] rnd;
        logic [BLK_W-1:0] inb;
        logic [BLK_W-1:0] work;
        logic [BLK_W-1:0] outb;
        logic             done;
    } regs_t;

    regs_t r_d, r_q;
    logic [BLK_W-1:0] rnd_out;
    logic             final_rnd;

    assign final_rnd = (r_q.rnd == '0);

    blkdec_round u_round (
        .st_in  (r_q.work),
        .rkey   (rk_data),
        .last   (final_rnd),
        .st_out (rnd_out)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            r_d.inb[(NWORDS - 1 - int'(wr_idx)) * WORD_W +: WORD_W] = wr_word;
        end
        unique case (r_q.phase)
            PH_IDLE: begin
                if (start) begin
                    r_d.work  = r_q.inb ^ rk_data;
                    r_d.rnd   = LAST_IDX - IDX_W'(1);
                    r_d.phase = PH_RUN;
                    r_d.done  = 1'b0;
                end
            end
            PH_RUN: begin
                r_d.work = rnd_out;
                if (final_rnd) begin
                    r_d.outb  = rnd_out;
                    r_d.phase = PH_FIN;
                end else begin
                    r_d.rnd = r_q.rnd - IDX_W'(1);
                end
            end
            default: begin
                r_d.phase = PH_IDLE;
                r_d.done  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rk_idx  = (r_q.phase == PH_RUN) ? r_q.rnd : LAST_IDX;
    assign done    = r_q.done;
    assign rd_word = r_q.outb[(NWORDS - 1 - int'(rd_idx)) * WORD_W +: WORD_W];

    // key index walks down by one per running round
    assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_RUN && r_q.rnd != '0) |=> (rk_idx == $past(rk_idx) - IDX_W'(1)));

    // done rises only the cycle after the output store
    assert_done_after_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(r_q.phase) == PH_FIN));

    // done holds until a start is accepted
    assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // a start while running does not disturb the run
    assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_RUN && start) |=> !done && (r_q.phase != PH_IDLE));

    // output buffer changes only on the final round
    assert_out_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.phase == PH_RUN && final_rnd) |=> $stable(r_q.outb));

endmodule

// File: tb/blkdec_core_tb.sv
module blkdec_core_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_idx = '0;
    logic [31:0]  wr_word = '0;
    logic         start = 1'b0;
    logic [3:0]   rk_idx;
    logic [127:0] rk_data;
    logic         done;
    logic [1:0]   rd_idx = '0;
    logic [31:0]  rd_word;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0]   fsb [256];
    logic [127:0] rk_tab [11];

    always #10 clk = ~clk;

    blkdec_core u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_word(wr_word), .start(start), .rk_idx(rk_idx),
        .rk_data(rk_data), .done(done), .rd_idx(rd_idx), .rd_word(rd_word)
    );

    assign rk_data = (rk_idx <= 4'd10) ? rk_tab[rk_idx] : '0;

    function automatic logic [7:0] m2(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc = 0, p = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc ^= p;
            p = m2(p);
        end
        return acc;
    endfunction

    function automatic logic [7:0] gb(input logic [127:0] s, input int b);
        return s[8*(15-b) +: 8];
    endfunction

    function automatic logic [127:0] encrypt(input logic [127:0] pt);
        logic [127:0] s, t;
        s = pt ^ rk_tab[0];
        for (int r = 1; r <= 10; r++) begin
            for (int b = 0; b < 16; b++) t[8*(15-b) +: 8] = fsb[gb(s, b)];
            for (int c = 0; c < 4; c++)
                for (int w = 0; w < 4; w++)
                    s[8*(15-(4*c+w)) +: 8] = gb(t, 4*((c+w)%4)+w);
            if (r < 10) begin
                t = s;
                for (int c = 0; c < 4; c++) begin
                    logic [7:0] a0, a1, a2, a3;
                    a0 = gb(t, 4*c); a1 = gb(t, 4*c+1); a2 = gb(t, 4*c+2); a3 = gb(t, 4*c+3);
                    s[8*(15-4*c)   +: 8] = m2(a0) ^ m2(a1) ^ a1 ^ a2 ^ a3;
                    s[8*(15-4*c-1) +: 8] = a0 ^ m2(a1) ^ m2(a2) ^ a2 ^ a3;
                    s[8*(15-4*c-2) +: 8] = a0 ^ a1 ^ m2(a2) ^ m2(a3) ^ a3;
                    s[8*(15-4*c-3) +: 8] = m2(a0) ^ a0 ^ a1 ^ a2 ^ m2(a3);
                end
            end
            s = s ^ rk_tab[r];
        end
        return s;
    endfunction

    task automatic set_key(input logic [127:0] key);
        logic [31:0] w [44];
        logic [7:0]  rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = key[32*(3-i) +: 32];
        for (int i = 4; i < 44; i++) begin
            logic [31:0] t = w[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {fsb[t[31:24]] ^ rc, fsb[t[23:16]], fsb[t[15:8]], fsb[t[7:0]]};
                rc = m2(rc);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int r = 0; r < 11; r++) rk_tab[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    endtask

    task automatic check(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_out(output logic [127:0] v);
        for (int i = 0; i < 4; i++) begin
            rd_idx = 2'(i);
            #1;
            v[32*(3-i) +: 32] = rd_word;
        end
    endtask

    // R2 load, R3 index walk, R5 timing, R6 clear, R7 ignored start, R4/R9 result
    task automatic run_block(input logic [127:0] ct, input logic [127:0] exp_pt,
                             input logic dup, input string tag);
        logic idx_ok = 1'b1, low_ok = 1'b1;
        logic [127:0] got;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_idx = 2'(i); wr_word = ct[32*(3-i) +: 32];
        end
        @(negedge clk);
        wr_en = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, {"R6 done cleared by start ", tag}, 128'(done), 128'd0);
        for (int k = 1; k <= 10; k++) begin
            if (rk_idx != 4'(10 - k)) idx_ok = 1'b0;
            if (done) low_ok = 1'b0;
            start = (dup && k == 3);
            @(negedge clk);
        end
        start = 1'b0;
        check(idx_ok && rk_idx == 4'd10, {"R3 R7 key index walk ", tag}, 128'(rk_idx), 128'd10);
        check(low_ok && !done, {"R5 R7 done low through 10 edges ", tag}, 128'(done), 128'd0);
        @(negedge clk);
        check(done == 1'b1, {"R5 done after 11th edge ", tag}, 128'(done), 128'd1);
        read_out(got);
        check(got == exp_pt, {"R2 R4 R9 plain text ", tag}, got, exp_pt);
    endtask

    initial begin
        #(20 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] v, key, pt, ct, held;
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 8'h00, s;
            for (int y = 1; y < 256; y++) if (mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            s = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
            fsb[x] = s;
        end
        set_key(128'h000102030405060708090a0b0c0d0e0f);
        repeat (3) @(negedge clk);
        // R1 reset state
        read_out(v);
        check(done == 1'b0 && rk_idx == 4'd10 && v == '0, "R1 reset state", {v[127:8], 3'b0, done, rk_idx}, 128'd10);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 known answer vector
        ct = encrypt(128'h00112233445566778899aabbccddeeff);
        check(ct == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R4 bench cipher model", ct, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        run_block(128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h00112233445566778899aabbccddeeff, 1'b0, "fips");

        // R8 output held while loading; R6 done held
        read_out(held);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_idx = 2'(i); wr_word = 32'hdead0000 | 32'(i);
        end
        @(negedge clk);
        wr_en = 1'b0;
        read_out(v);
        check(v == held, "R8 output unchanged by input writes", v, held);
        check(done == 1'b1, "R6 done held while idle", 128'(done), 128'd1);

        // R7 start pulse mid-run ignored
        run_block(128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h00112233445566778899aabbccddeeff, 1'b1, "dup start");

        // sweep: first plaintext byte across a range, random keys
        for (int n = 0; n < 48; n++) begin
            key = {$urandom, $urandom, $urandom, $urandom};
            pt  = {8'(n * 5), 24'($urandom), $urandom, $urandom, $urandom};
            set_key(key);
            ct = encrypt(pt);
            run_block(ct, pt, (n % 7 == 3), $sformatf("rand%0d", n));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule